// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block is the host side of a link to a multiplexed serial analog-to-digital converter. The converter is controlled by one strobe line that both starts a conversion and frames the transfer, plus a serial clock, a host-to-converter data line and a converter-to-host data line. The sequencer holds a small list of 7-bit channel configuration words. It walks that list in a loop: for each entry it raises the strobe, waits out the conversion time, and then runs one 16-clock serial frame. During the frame it sends the entry's configuration word and collects a 16-bit result.

The converter applies a configuration word to the acquisition that follows the frame that carried it. The result read in any frame therefore belongs to the entry sent one frame earlier. The sequencer tracks this offset. It tags each result with the list index that produced it and drops the first result after every start, because no configuration preceded that frame. Results leave on a valid/ready stream, and the sequencer stalls while the consumer is not ready. The strobe timing selects between two power behaviours. In nap timing the strobe stays high for the whole conversion window. In full-power timing it is a one-cycle pulse. A configuration with its sleep bit set makes the sequencer wait a programmable wake-up interval before the next strobe.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A list entry is written through `list_wr_*`, with bit 6 first on `adc_mosi` and bit 0 last. The field order from bit 6 down to bit 0 is: single-ended select, odd/sign, address high, address low, common-reference select, unipolar select, sleep request. Frame clocks 8 to 16 send 0.
- R2: `adc_sck` idles low and toggles only while `adc_cs` is low. `adc_mosi` changes only on a falling `adc_sck` and stays stable while `adc_sck` is high. `adc_miso` is sampled on each of the 16 rising edges, and the first sample is the result MSB.
- R3: The first rising `adc_sck` of a frame comes exactly `C + H` clock cycles after `adc_cs` rises. C is the effective conversion time and H is the effective half period.
- R4: The effective conversion time C is `conv_cycles`, but never less than 2. With `nap_en`=1 the strobe stays high for exactly C cycles. With `nap_en`=0 it is high for exactly one cycle.
- R5: After `run` is raised from idle, entries are sent in the order 0, 1, …, `list_last`, then the order wraps back to 0.
- R6: Every result beat carries in `res_tag` the index of the entry sent in the preceding frame, and `res_data` is the word received in the frame that follows it.
- R7: The result of the first frame after `run` is raised is discarded. Over a run, the number of beats is one less than the number of frames.
- R8: While `res_valid` is high and `res_ready` is low, `res_data` and `res_tag` hold steady and no new strobe is raised.
- R9: After a frame whose configuration has its sleep bit (bit 0) set, at least `wake_cycles` cycles pass between the last falling `adc_sck` of that frame and the next rising `adc_cs`.
- R10: After reset, and after `run` falls and the frame in progress has been delivered, `adc_cs`, `adc_sck` and `res_valid` are low and no further strobe is issued.
- R11: Each high phase of `adc_sck` lasts exactly H cycles, where H is `sck_half` and a value of 0 counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Keep sequencing while high |
| nap_en | input | 1 | 1: strobe held through conversion; 0: one-cycle strobe |
| sck_half | input | HALF_W | Serial clock half period in system cycles |
| conv_cycles | input | TIME_W | Conversion time in system cycles |
| wake_cycles | input | WAKE_W | Wake-up wait after a sleep request |
| list_last | input | IDX_W | Index of the last active list entry |
| list_wr_en | input | 1 | Write strobe for a list entry |
| list_wr_idx | input | IDX_W | Entry index to write |
| list_wr_cfg | input | 7 | Configuration word to store |
| adc_cs | output | 1 | Convert strobe / frame select |
| adc_sck | output | 1 | Serial clock |
| adc_mosi | output | 1 | Configuration bit to the converter |
| adc_miso | input | 1 | Result bit from the converter |
| res_valid | output | 1 | Result beat valid |
| res_ready | input | 1 | Consumer ready |
| res_data | output | 16 | Conversion result |
| res_tag | output | IDX_W | List index that produced the result |

## Verification
The bench targets the one-frame offset between a configuration and its data. A design that forgets the discard would emit a stale first beat and break the beat-to-frame count. A design with the offset wrong would tag each result with the entry that is still being acquired. It also drives zero conversion times and zero half periods, where a missing clamp would produce a strobe narrower than the conversion or a stuck serial clock. The exact strobe-to-first-edge distance in both nap and full-power timing is measured, so an off-by-one in the conversion counter shows up. Finally, the bench mixes sleep-bit entries with a zero or non-zero wake interval and a sparse ready signal. A design that skips the wake wait, or that lets data slip while stalled, is reported.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CFG_W     = 7;
    localparam int RES_W     = 16;
    localparam int FRAME_LEN = 16;
    localparam int MIN_CONV  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_CONV,
        ST_SHIFT,
        ST_OUT
    } seq_state_t;

    // Field order is the wire order: the top field leaves first.
    typedef struct packed {
        logic       single_end;
        logic       odd_sign;
        logic [1:0] addr;
        logic       com_ref;
        logic       unipolar;
        logic       sleep_req;
    } adc_cfg_t;

    function automatic logic [FRAME_LEN-1:0] frame_of(adc_cfg_t c);
        return {c, {(FRAME_LEN - CFG_W){1'b0}}};
    endfunction

endpackage

// File: rtl/adc_seq_cfg_list.sv
module adc_seq_cfg_list
    import adc_seq_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  adc_cfg_t         wr_cfg,
    input  logic [IDX_W-1:0] rd_idx,
    output adc_cfg_t         rd_cfg
);

    adc_cfg_t         entry_q [N_ENTRIES];
    logic [N_ENTRIES-1:0] hit;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_dec
        assign hit[g] = wr_en && (wr_idx == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (rst)
                entry_q[i] <= '0;
            else if (hit[i])
                entry_q[i] <= wr_cfg;
        end
    end

    assign rd_cfg = entry_q[rd_idx];

endmodule

// File: rtl/adc_seq_sclk_gen.sv
module adc_seq_sclk_gen #(
    parameter int HALF_W = 8,
    parameter int BITS   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [HALF_W-1:0] half,
    output logic              sck,
    output logic              rise_stb,
    output logic              fall_stb,
    output logic              last_stb
);

    localparam int BIT_W = $clog2(BITS);

    logic [HALF_W-1:0] half_eff;
    logic [HALF_W-1:0] hcnt_q;
    logic [BIT_W-1:0]  bitn_q;
    logic              phase_q;
    logic              wrap;

    assign half_eff = (half == '0) ? HALF_W'(1) : half;
    assign wrap     = en && (hcnt_q == half_eff - HALF_W'(1));
    assign rise_stb = wrap && !phase_q;
    assign fall_stb = wrap && phase_q;
    assign last_stb = fall_stb && (bitn_q == BIT_W'(BITS - 1));
    assign sck      = phase_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hcnt_q  <= '0;
            bitn_q  <= '0;
            phase_q <= 1'b0;
        end else if (wrap) begin
            hcnt_q  <= '0;
            phase_q <= !phase_q;
            if (phase_q)
                bitn_q <= bitn_q + BIT_W'(1);
        end else begin
            hcnt_q <= hcnt_q + HALF_W'(1);
        end
    end

endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  adc_cfg_t         load_cfg,
    input  logic             rise_stb,
    input  logic             fall_stb,
    input  logic             miso,
    output logic             mosi,
    output logic [RES_W-1:0] rx_word
);

    logic [FRAME_LEN-1:0] tx_q;
    logic [FRAME_LEN-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load)
                tx_q <= frame_of(load_cfg);
            else if (fall_stb)
                tx_q <= {tx_q[FRAME_LEN-2:0], 1'b0};
            if (rise_stb)
                rx_q <= {rx_q[FRAME_LEN-2:0], miso};
        end
    end

    assign mosi    = tx_q[FRAME_LEN-1];
    assign rx_word = rx_q[RES_W-1:0];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int HALF_W    = 8,
    parameter int TIME_W    = 16,
    parameter int WAKE_W    = 24,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              nap_en,
    input  logic [HALF_W-1:0] sck_half,
    input  logic [TIME_W-1:0] conv_cycles,
    input  logic [WAKE_W-1:0] wake_cycles,
    input  logic [IDX_W-1:0]  list_last,
    input  logic              list_wr_en,
    input  logic [IDX_W-1:0]  list_wr_idx,
    input  logic [CFG_W-1:0]  list_wr_cfg,
    output logic              adc_cs,
    output logic              adc_sck,
    output logic              adc_mosi,
    input  logic              adc_miso,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [RES_W-1:0]  res_data,
    output logic [IDX_W-1:0]  res_tag
);

    localparam int CNT_W = (TIME_W > WAKE_W) ? TIME_W : WAKE_W;

    seq_state_t        state_q;
    logic [CNT_W-1:0]  tmr_q;
    logic [CNT_W-1:0]  conv_eff;
    logic [CNT_W-1:0]  wake_lim;
    logic [IDX_W-1:0]  ptr_q;
    logic [IDX_W-1:0]  prev_idx_q;
    logic              prime_q;
    logic              nap_q;
    logic              sent_sleep_q;
    logic              sleep_pend_q;
    logic              out_valid_q;
    logic [RES_W-1:0]  out_data_q;
    logic [IDX_W-1:0]  out_tag_q;

    adc_cfg_t          cur_cfg;
    logic              load_frame;
    logic              rise_stb;
    logic              fall_stb;
    logic              last_stb;
    logic [RES_W-1:0]  rx_word;
    logic              need_wake;
    logic [IDX_W-1:0]  ptr_next;

    assign conv_eff   = (conv_cycles < TIME_W'(MIN_CONV)) ? CNT_W'(MIN_CONV) : CNT_W'(conv_cycles);
    assign wake_lim   = CNT_W'(wake_cycles);
    assign need_wake  = sleep_pend_q && (wake_cycles != '0);
    assign load_frame = (state_q == ST_CONV) && (tmr_q == conv_eff - CNT_W'(1));
    assign ptr_next   = (ptr_q >= list_last) ? '0 : ptr_q + IDX_W'(1);

    adc_seq_cfg_list #(
        .N_ENTRIES (N_ENTRIES),
        .IDX_W     (IDX_W)
    ) list_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (list_wr_en),
        .wr_idx (list_wr_idx),
        .wr_cfg (adc_cfg_t'(list_wr_cfg)),
        .rd_idx (ptr_q),
        .rd_cfg (cur_cfg)
    );

    adc_seq_sclk_gen #(
        .HALF_W (HALF_W),
        .BITS   (FRAME_LEN)
    ) sclk_i (
        .clk      (clk),
        .rst      (rst),
        .en       (state_q == ST_SHIFT),
        .half     (sck_half),
        .sck      (adc_sck),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .last_stb (last_stb)
    );

    adc_seq_shifter shift_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load_frame),
        .load_cfg (cur_cfg),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .miso     (adc_miso),
        .mosi     (adc_mosi),
        .rx_word  (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            tmr_q        <= '0;
            ptr_q        <= '0;
            prev_idx_q   <= '0;
            prime_q      <= 1'b0;
            nap_q        <= 1'b0;
            sent_sleep_q <= 1'b0;
            sleep_pend_q <= 1'b0;
            out_valid_q  <= 1'b0;
            out_data_q   <= '0;
            out_tag_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (run) begin
                        ptr_q   <= '0;
                        prime_q <= 1'b1;
                        tmr_q   <= '0;
                        if (need_wake) begin
                            state_q <= ST_WAKE;
                        end else begin
                            state_q      <= ST_CONV;
                            nap_q        <= nap_en;
                            sleep_pend_q <= 1'b0;
                        end
                    end
                end
                ST_WAKE: begin
                    if (tmr_q == wake_lim - CNT_W'(1)) begin
                        state_q      <= ST_CONV;
                        tmr_q        <= '0;
                        nap_q        <= nap_en;
                        sleep_pend_q <= 1'b0;
                    end else begin
                        tmr_q <= tmr_q + CNT_W'(1);
                    end
                end
                ST_CONV: begin
                    if (load_frame) begin
                        state_q      <= ST_SHIFT;
                        tmr_q        <= '0;
                        sent_sleep_q <= cur_cfg.sleep_req;
                    end else begin
                        tmr_q <= tmr_q + CNT_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (last_stb) begin
                        state_q      <= ST_OUT;
                        out_data_q   <= rx_word;
                        out_tag_q    <= prev_idx_q;
                        out_valid_q  <= !prime_q;
                        prime_q      <= 1'b0;
                        prev_idx_q   <= ptr_q;
                        ptr_q        <= ptr_next;
                        sleep_pend_q <= sent_sleep_q;
                    end
                end
                ST_OUT: begin
                    if (!out_valid_q || res_ready) begin
                        out_valid_q <= 1'b0;
                        tmr_q       <= '0;
                        if (!run) begin
                            state_q <= ST_IDLE;
                        end else if (need_wake) begin
                            state_q <= ST_WAKE;
                        end else begin
                            state_q      <= ST_CONV;
                            nap_q        <= nap_en;
                            sleep_pend_q <= 1'b0;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign adc_cs    = (state_q == ST_CONV) && (nap_q || (tmr_q == '0));
    assign res_valid = out_valid_q;
    assign res_data  = out_data_q;
    assign res_tag   = out_tag_q;

    AST_SCK_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_SHIFT) |-> !adc_sck); // R2
    AST_CS_LOW_WHEN_CLOCKING: assert property (@(posedge clk) disable iff (rst)
        adc_sck |-> !adc_cs); // R2
    AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
        (adc_sck && $past(adc_sck)) |-> $stable(adc_mosi)); // R2
    AST_FULL_POWER_PULSE: assert property (@(posedge clk) disable iff (rst)
        ($rose(adc_cs) && !nap_q) |=> !adc_cs); // R4
    AST_NAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($rose(adc_cs) && nap_q) |=> adc_cs); // R4
    AST_TAG_IN_LIST: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_tag <= list_last)); // R6
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_tag))); // R8
    AST_NO_STROBE_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !adc_cs); // R8

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_ENT      = 8;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        nap_en = 1'b0;
    logic [7:0]  sck_half = 8'd1;
    logic [15:0] conv_cycles = 16'd2;
    logic [23:0] wake_cycles = 24'd0;
    logic [2:0]  list_last = 3'd0;
    logic        list_wr_en = 1'b0;
    logic [2:0]  list_wr_idx = 3'd0;
    logic [6:0]  list_wr_cfg = 7'd0;
    logic        adc_cs, adc_sck, adc_mosi;
    logic        adc_miso = 1'b0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [15:0] res_data;
    logic [2:0]  res_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .nap_en      (nap_en),
        .sck_half    (sck_half),
        .conv_cycles (conv_cycles),
        .wake_cycles (wake_cycles),
        .list_last   (list_last),
        .list_wr_en  (list_wr_en),
        .list_wr_idx (list_wr_idx),
        .list_wr_cfg (list_wr_cfg),
        .adc_cs      (adc_cs),
        .adc_sck     (adc_sck),
        .adc_mosi    (adc_mosi),
        .adc_miso    (adc_miso),
        .res_valid   (res_valid),
        .res_ready   (res_ready),
        .res_data    (res_data),
        .res_tag     (res_tag)
    );

    int checks = 0;
    int errors = 0;

    logic [6:0] lst [N_ENT];
    int last_v = 0, half_eff_v = 1, conv_eff_v = 2, wake_v = 0, rdy_mode = 0;
    bit nap_v = 1'b0;
    int exp_ptr = 0, exp_tag = 0, beats = 0, xfers = 0, cs_rises = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(logic [6:0] c);
        return {c, ~c, 2'b10};
    endfunction

    // Converter model: config takes effect on the conversion after its frame.
    logic [6:0]  dev_rx = '0, dev_pend = '0, dev_conv = '0;
    logic [15:0] dev_sh = '0;
    int          dev_bit = 0;
    bit          last_sleep = 1'b0;

    always @(posedge adc_cs) begin
        dev_conv = dev_pend;
        dev_bit  = 0;
    end

    always @(negedge adc_cs) begin
        dev_sh   = exp_word(dev_conv);
        adc_miso = dev_sh[15];
    end

    always @(negedge adc_sck) begin
        dev_sh   = {dev_sh[14:0], 1'b0};
        adc_miso = dev_sh[15];
    end

    always @(posedge adc_sck) begin
        if (dev_bit < 7)
            dev_rx = {dev_rx[5:0], adc_mosi};
        else
            check(adc_mosi == 1'b0, "R1", "padding bit", adc_mosi, 0);
        dev_bit++;
        if (dev_bit == 16) begin
            check(dev_rx == lst[exp_ptr], "R5", "config word sent", dev_rx, lst[exp_ptr]);
            dev_pend   = dev_rx;
            last_sleep = dev_rx[0];
            exp_ptr    = (exp_ptr >= last_v) ? 0 : exp_ptr + 1;
            xfers++;
        end
    end

    // Timing monitor, sampled between edges.
    bit cs_p = 1'b0, sck_p = 1'b0, first_pend = 1'b0;
    int since_rise = 0, hi_cnt = 0, cs_hi = 0, since_fall = 1000;

    always @(negedge clk) begin
        if (!rst) begin
            if (adc_cs && !cs_p) begin
                since_rise = 0;
                cs_hi      = 1;
                cs_rises++;
                first_pend = 1'b1;
                if (last_sleep)
                    check(since_fall >= wake_v, "R9", "wake gap", since_fall, wake_v);
            end else begin
                since_rise++;
                if (adc_cs) cs_hi++;
            end
            if (!adc_cs && cs_p)
                check(cs_hi == (nap_v ? conv_eff_v : 1), "R4", "strobe width",
                      cs_hi, nap_v ? conv_eff_v : 1);
            if (adc_sck && adc_cs)
                check(1'b0, "R2", "sck high with strobe high", 1, 0);
            if (adc_sck && !sck_p) begin
                hi_cnt = 1;
                if (first_pend) begin
                    check(since_rise == conv_eff_v + half_eff_v, "R3", "strobe to first edge",
                          since_rise, conv_eff_v + half_eff_v);
                    first_pend = 1'b0;
                end
            end else if (adc_sck) begin
                hi_cnt++;
            end
            if (!adc_sck && sck_p) begin
                check(hi_cnt == half_eff_v, "R11", "sck high phase", hi_cnt, half_eff_v);
                since_fall = 0;
            end else begin
                since_fall++;
            end
            cs_p  = adc_cs;
            sck_p = adc_sck;
        end
    end

    // Result stream checker.
    bit         stall_p = 1'b0;
    logic [15:0] stall_d = '0;
    logic [2:0]  stall_t = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (stall_p) begin
                check(res_valid == 1'b1, "R8", "valid held in stall", res_valid, 1);
                check(res_data == stall_d, "R8", "data held in stall", res_data, stall_d);
                check(res_tag == stall_t, "R8", "tag held in stall", res_tag, stall_t);
            end
            if (res_valid && res_ready) begin
                check(res_tag == 3'(exp_tag), "R6", "result tag", res_tag, exp_tag);
                check(res_data == exp_word(lst[exp_tag]), "R6", "result data",
                      res_data, exp_word(lst[exp_tag]));
                exp_tag = (exp_tag >= last_v) ? 0 : exp_tag + 1;
                beats++;
            end
            stall_p = res_valid && !res_ready;
            stall_d = res_data;
            stall_t = res_tag;
        end
    end

    // Ready driver, changed just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            case (rdy_mode)
                0:       res_ready = 1'b1;
                1:       res_ready = (($urandom % 2) == 0);
                default: res_ready = (($urandom % 5) == 0);
            endcase
        end
    end

    task automatic setup(input int last, input int half, input int conv, input bit nap,
                         input int wake, input int rmode);
        @(negedge clk);
        list_last   = last[2:0];
        sck_half    = half[7:0];
        conv_cycles = conv[15:0];
        nap_en      = nap;
        wake_cycles = wake[23:0];
        rdy_mode    = rmode;
        last_v      = last;
        half_eff_v  = (half == 0) ? 1 : half;
        conv_eff_v  = (conv < 2) ? 2 : conv;
        nap_v       = nap;
        wake_v      = wake;
    endtask

    // kind 0: fixed pattern, no sleep; 1: random with sleep; 2: random, no sleep
    task automatic load_list(input int kind);
        for (int i = 0; i < N_ENT; i++) begin
            logic [6:0] c;
            if (kind == 0)
                c = 7'((i * 19 + 5) & 32'h7E);
            else if (kind == 1)
                c = 7'($urandom);
            else
                c = 7'($urandom) & 7'h7E;
            @(negedge clk);
            list_wr_en  = 1'b1;
            list_wr_idx = 3'(i);
            list_wr_cfg = c;
            lst[i]      = c;
        end
        @(negedge clk);
        list_wr_en = 1'b0;
    endtask

    task automatic run_seg(input int nbeats);
        int rises0;
        exp_ptr = 0;
        exp_tag = 0;
        beats   = 0;
        xfers   = 0;
        @(negedge clk);
        run = 1'b1;
        while (beats < nbeats) @(negedge clk);
        run = 1'b0;
        repeat (900) @(negedge clk);
        check(adc_cs == 1'b0, "R10", "strobe idle after stop", adc_cs, 0);
        check(adc_sck == 1'b0, "R10", "sck idle after stop", adc_sck, 0);
        check(res_valid == 1'b0, "R10", "valid idle after stop", res_valid, 0);
        check(beats == xfers - 1, "R7", "beats per frames", beats, xfers - 1);
        rises0 = cs_rises;
        repeat (60) @(negedge clk);
        check(cs_rises == rises0, "R10", "no strobe while stopped", cs_rises, rises0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N_ENT; i++) lst[i] = '0;
        repeat (5) @(negedge clk);
        check(adc_cs == 1'b0, "R10", "strobe in reset", adc_cs, 0);
        check(adc_sck == 1'b0, "R10", "sck in reset", adc_sck, 0);
        check(res_valid == 1'b0, "R10", "valid in reset", res_valid, 0);
        rst = 1'b0;

        // Directed: nap timing, four entries, ready always high.
        setup(3, 1, 3, 1'b1, 4, 0);
        load_list(0);
        run_seg(10);

        // Directed: clamped zero conversion time and zero half period, single entry.
        setup(0, 0, 0, 1'b0, 0, 0);
        load_list(2);
        run_seg(6);

        // Directed: full list with sleep bits, sparse ready (stalls).
        setup(7, 2, 5, 1'b0, 10, 2);
        load_list(1);
        run_seg(12);

        // Directed: sleep bits with zero wake interval, nap timing.
        setup(2, 3, 8, 1'b1, 0, 1);
        load_list(1);
        run_seg(7);

        // Random segments.
        for (int s = 0; s < 8; s++) begin
            int ll, hv, cv, wv, rm, nb;
            bit nv;
            ll = $urandom % 8;
            hv = $urandom % 4;
            cv = $urandom % 9;
            wv = $urandom % 31;
            rm = $urandom % 3;
            nb = 5 + ($urandom % 11);
            nv = 1'($urandom % 2);
            setup(ll, hv, cv, nv, wv, rm);
            load_list(1 + ($urandom % 2));
            run_seg(nb);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule